// File: doc/BRIEF.md
# One-Shot Write Checksum Readback Controller

This block sits on the read data path of a secure serial memory. A write made after a successful authentication arms a checksum mode. While the mode is armed, a read command that starts at the checksum address (0x20 by default) returns the eight bytes of a 64-bit write checksum instead of the stored contents. An external pseudo-random generator computes that checksum from the written bytes and presents it on `csum_in`. The block keeps the read address counter and decides, byte by byte, whether the checksum register or the memory supplies the outgoing byte.

Each authentication allows one arming of the mode. The mode ends when the checksum read finishes, however short it was. It also ends once all eight checksum bytes have been taken, and the same read then carries on from memory at 0x28. A read that starts at any other address ends the mode as well. When the unlimited-readback control is low, these endings do not apply, and the checksum can be read any number of times until the next authentication or reset.

Read bytes leave on a valid/ready stream. `dout_valid` stays high from the start of a read command until its end. A byte is taken on a clock edge where `dout_valid` and `dout_ready` are both high. While `dout_ready` is low, the byte and the address are held. The memory must return `mem_rdata` for the current `mem_addr` in the same cycle.

Top module: `csum_readback`

## Requirements
- R1: While reset is low, and after reset, `dout_valid` and `csum_mode` are 0 and `mem_addr` is 0.
- R2: A `wr_cmd` pulse sets `csum_mode` at the next edge only if an `auth_ok` pulse has arrived since reset. A write with no authentication since reset has no effect, and a later read at 0x20 returns memory data with `dout_is_csum` 0.
- R3: A read that starts at 0x20 while `csum_mode` is 1 returns the checksum most significant byte first, from `csum_in[63:56]` down to `csum_in[7:0]`, with `dout_is_csum` 1. The value used is `csum_in` as it was in the `rd_start` cycle, and later changes to `csum_in` have no effect on that read.
- R4: An `rd_end` that finishes a checksum read clears `csum_mode`, however many bytes were taken. A following read at 0x20 returns memory data.
- R5: An `rd_start` whose address is not 0x20 clears `csum_mode` and returns memory data from that address.
- R6: After the mode has been armed once, further writes do not set it again until the next `auth_ok`.
- R7: `mem_addr` loads the start address on `rd_start` and rises by one for each byte taken. Once the eighth checksum byte is taken, `csum_mode` is 0 and the following bytes come from memory, starting at 0x28.
- R8: With `unlim_rd_n` at 0, neither reads nor read ends clear the mode, and every read at 0x20 returns the checksum again.
- R9: While `dout_valid` is 1 and `dout_ready` is 0, `dout_data`, `dout_is_csum` and `mem_addr` hold their values.
- R10: Reset and `auth_ok` both clear `csum_mode` and the used-once state. After reset, a write arms nothing until a new `auth_ok`. After `auth_ok`, a single write arms the mode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auth_ok | input | 1 | One-cycle pulse: an authentication just succeeded |
| wr_cmd | input | 1 | One-cycle pulse: a write command was accepted |
| unlim_rd_n | input | 1 | Active low: 0 allows unlimited checksum reads |
| rd_start | input | 1 | One-cycle pulse: a read command begins at `rd_addr` |
| rd_addr | input | 8 | Start address of the read command |
| rd_end | input | 1 | One-cycle pulse: the read command is over |
| csum_in | input | 64 | Checksum from the generator, sampled on `rd_start` |
| mem_addr | output | 8 | Address counter, read address to memory |
| mem_rdata | input | 8 | Memory byte at `mem_addr` |
| dout_valid | output | 1 | A read byte is on offer |
| dout_ready | input | 1 | Consumer takes the byte this cycle |
| dout_data | output | 8 | Outgoing read byte |
| dout_is_csum | output | 1 | Current byte comes from the checksum register |
| csum_mode | output | 1 | Checksum mode armed |

## Verification
A wrong armed or used flag shows on `csum_mode` one edge after the write, read or authentication pulse that set it wrong. It then shows as memory data instead of checksum data, or checksum data instead of memory data, on the first byte of the next read at 0x20. A wrong byte index or address counter shows on `dout_data` and `mem_addr` in the cycle after the byte handshake. The effect is most visible at the handover from the eighth checksum byte to address 0x28. A reference model in the bench follows every pulse, and the bench compares its outputs with the design on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/csum_rb_pkg.sv
package csum_rb_pkg;
  localparam int DEF_ADDR_W    = 8;
  localparam int DEF_BYTES     = 8;
  localparam int DEF_CSUM_ADDR = 32'h20;
  localparam int DATA_W        = 8;

  typedef struct packed {
    logic auth;
    logic wr;
    logic rd_start;
    logic rd_end;
  } cmd_ev_t;
endpackage

// File: rtl/csum_mode_ctrl.sv
module csum_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic auth_ok,
  input  logic wr_cmd,
  input  logic unlimited,
  input  logic end_req,
  output logic armed
);
  logic authd;
  logic used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      authd <= 1'b0;
      used  <= 1'b0;
      armed <= 1'b0;
    end else if (auth_ok) begin
      authd <= 1'b1;
      used  <= 1'b0;
      armed <= 1'b0;
    end else if (wr_cmd && authd && (!used || unlimited)) begin
      armed <= 1'b1;
      used  <= 1'b1;
    end else if (end_req) begin
      armed <= 1'b0;
    end
  end

  // R2: the mode only rises after a write made while authenticated
  a_r2_arm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_cmd && authd));

  // R6: once used, a write cannot re-arm without a new authentication
  a_r6_single_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (used && !armed && !unlimited && !auth_ok) |=> !armed);

  // R10: authentication always leaves the mode cleared
  a_r10_auth_clears: assert property (@(posedge clk) disable iff (!rst_n)
    auth_ok |=> !armed);
endmodule

// File: rtl/csum_rd_track.sv
module csum_rd_track #(
  parameter int ADDR_W    = csum_rb_pkg::DEF_ADDR_W,
  parameter int NBYTES    = csum_rb_pkg::DEF_BYTES,
  parameter int CSUM_ADDR = csum_rb_pkg::DEF_CSUM_ADDR,
  localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CS_W     = NBYTES * csum_rb_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_end,
  input  logic              dout_ready,
  input  logic              armed,
  input  logic              unlimited,
  input  logic [CS_W-1:0]   csum_in,
  output logic              reading,
  output logic [ADDR_W-1:0] addr,
  output logic              ovl,
  output logic [IDX_W-1:0]  idx,
  output logic [CS_W-1:0]   cs_q,
  output logic              end_req
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = CSUM_ADDR[ADDR_W-1:0];
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NBYTES - 1);

  logic csrd;
  logic acc;
  logic last;
  logic hit;

  assign hit  = (rd_addr == HIT_ADDR);
  assign acc  = reading && dout_ready && !rd_start && !rd_end;
  assign last = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reading <= 1'b0;
      addr    <= '0;
      ovl     <= 1'b0;
      csrd    <= 1'b0;
      idx     <= '0;
      cs_q    <= '0;
    end else if (rd_start) begin
      reading <= 1'b1;
      addr    <= rd_addr;
      ovl     <= armed && hit;
      csrd    <= armed && hit;
      idx     <= '0;
      cs_q    <= csum_in;
    end else if (rd_end) begin
      reading <= 1'b0;
      ovl     <= 1'b0;
      csrd    <= 1'b0;
    end else if (acc) begin
      addr <= addr + 1'b1;
      if (ovl) begin
        if (last) ovl <= 1'b0;
        else      idx <= idx + 1'b1;
      end
    end
  end

  assign end_req = !unlimited &&
                   ((rd_start && !hit) || (rd_end && csrd) || (acc && ovl && last));

  // R7: every byte taken moves the address counter on by one
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (addr == $past(addr) + 1'b1));

  // R7: the overlay never outlasts the last checksum byte
  a_r7_ovl_len: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ovl && last) |=> !ovl);

  // R9: a stalled byte keeps its address and index
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !dout_ready && !rd_start && !rd_end) |=>
      ((addr == $past(addr)) && (idx == $past(idx))));

  // R3: checksum bytes only appear inside a read command
  a_r3_ovl_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    ovl |-> reading);
endmodule

// File: rtl/csum_out_mux.sv
module csum_out_mux #(
  parameter int NBYTES   = csum_rb_pkg::DEF_BYTES,
  localparam int DW      = csum_rb_pkg::DATA_W,
  localparam int IDX_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CS_W    = NBYTES * DW
) (
  input  logic             ovl,
  input  logic [IDX_W-1:0] idx,
  input  logic [CS_W-1:0]  cs_q,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    dout_data,
  output logic             dout_is_csum
);
  logic [DW-1:0] bsel [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign bsel[k] = cs_q[(NBYTES-k)*DW-1 -: DW];
  end

  assign dout_data    = ovl ? bsel[idx] : mem_rdata;
  assign dout_is_csum = ovl;
endmodule

// File: rtl/csum_readback.sv
module csum_readback #(
  parameter int ADDR_W    = csum_rb_pkg::DEF_ADDR_W,
  parameter int NBYTES    = csum_rb_pkg::DEF_BYTES,
  parameter int CSUM_ADDR = csum_rb_pkg::DEF_CSUM_ADDR,
  localparam int DW       = csum_rb_pkg::DATA_W,
  localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CS_W     = NBYTES * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auth_ok,
  input  logic              wr_cmd,
  input  logic              unlim_rd_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_end,
  input  logic [CS_W-1:0]   csum_in,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [DW-1:0]     dout_data,
  output logic              dout_is_csum,
  output logic              csum_mode
);
  csum_rb_pkg::cmd_ev_t ev;
  logic                 unlimited;
  logic                 armed;
  logic                 reading;
  logic [ADDR_W-1:0]    addr;
  logic                 ovl;
  logic [IDX_W-1:0]     idx;
  logic [CS_W-1:0]      cs_q;
  logic                 end_req;

  assign ev        = '{auth: auth_ok, wr: wr_cmd, rd_start: rd_start, rd_end: rd_end};
  assign unlimited = !unlim_rd_n;

  csum_mode_ctrl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .auth_ok  (ev.auth),
    .wr_cmd   (ev.wr),
    .unlimited(unlimited),
    .end_req  (end_req),
    .armed    (armed)
  );

  csum_rd_track #(
    .ADDR_W   (ADDR_W),
    .NBYTES   (NBYTES),
    .CSUM_ADDR(CSUM_ADDR)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_start  (ev.rd_start),
    .rd_addr   (rd_addr),
    .rd_end    (ev.rd_end),
    .dout_ready(dout_ready),
    .armed     (armed),
    .unlimited (unlimited),
    .csum_in   (csum_in),
    .reading   (reading),
    .addr      (addr),
    .ovl       (ovl),
    .idx       (idx),
    .cs_q      (cs_q),
    .end_req   (end_req)
  );

  csum_out_mux #(
    .NBYTES(NBYTES)
  ) u_mux (
    .ovl         (ovl),
    .idx         (idx),
    .cs_q        (cs_q),
    .mem_rdata   (mem_rdata),
    .dout_data   (dout_data),
    .dout_is_csum(dout_is_csum)
  );

  assign mem_addr   = addr;
  assign dout_valid = reading;
  assign csum_mode  = armed;

  // R5: a read elsewhere ends the limited mode
  a_r5_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !auth_ok && !wr_cmd && unlim_rd_n &&
     (rd_addr != CSUM_ADDR[ADDR_W-1:0])) |=> !csum_mode);

  // R8: in unlimited mode read events never drop the mode
  a_r8_unlimited_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (csum_mode && !unlim_rd_n && !auth_ok) |=> csum_mode);

  // R1: nothing is offered outside a read command after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!dout_valid && !csum_mode));
endmodule

// File: tb/csum_readback_bench.sv
`timescale 1ns/1ps
module csum_readback_bench;
  localparam logic [63:0] C1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] C2 = 64'hFEDC_BA98_7654_3210;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auth_ok = 1'b0, wr_cmd = 1'b0, unlim_rd_n = 1'b1;
  logic        rd_start = 1'b0, rd_end = 1'b0, dout_ready = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic [63:0] csum_in = C1;
  logic [7:0]  mem_addr, mem_rdata, dout_data;
  logic        dout_valid, dout_is_csum, csum_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction
  assign mem_rdata = memf(mem_addr);

  csum_readback u_csum_readback (
    .clk(clk), .rst_n(rst_n), .auth_ok(auth_ok), .wr_cmd(wr_cmd),
    .unlim_rd_n(unlim_rd_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_end(rd_end), .csum_in(csum_in), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_data(dout_data), .dout_is_csum(dout_is_csum), .csum_mode(csum_mode)
  );

  // behavioural reference model
  bit      m_auth, m_used, m_armed, m_rd, m_ovl, m_csrd;
  int      m_addr, m_cnt;
  byte     m_q[$];

  always @(posedge clk) begin
    bit unl;
    bit acc;
    unl = !unlim_rd_n;
    acc = m_rd && dout_ready && !rd_start && !rd_end;
    if (!rst_n) begin
      m_auth = 0; m_used = 0; m_armed = 0; m_rd = 0; m_ovl = 0; m_csrd = 0;
      m_addr = 0; m_cnt = 0; m_q.delete();
    end else begin
      if (auth_ok) begin
        m_auth = 1; m_used = 0; m_armed = 0;
      end else if (wr_cmd && m_auth && (!m_used || unl)) begin
        m_armed = 1; m_used = 1;
      end
      if (rd_start) begin
        m_rd = 1; m_addr = rd_addr; m_cnt = 0; m_q.delete();
        m_ovl = m_armed && (rd_addr == 8'h20);
        m_csrd = m_ovl;
        for (int k = 7; k >= 0; k--) m_q.push_back(csum_in[k*8 +: 8]);
        if (rd_addr != 8'h20 && !unl) m_armed = 0;
      end else if (rd_end) begin
        if (m_csrd && !unl) m_armed = 0;
        m_rd = 0; m_ovl = 0; m_csrd = 0;
      end else if (acc) begin
        m_addr = (m_addr + 1) % 256;
        if (m_ovl) begin
          m_cnt++;
          if (m_cnt == 8) begin
            m_ovl = 0;
            if (!unl) m_armed = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison; outputs depend only on registers and mem_rdata(mem_addr)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 valid", dout_valid, m_rd);
      chk("R2 mode", csum_mode, m_armed);
      chk("R7 addr", mem_addr, m_addr[7:0]);
      chk("R3 is_csum", dout_is_csum, m_ovl);
      chk("R3 data", dout_data, m_ovl ? m_q[m_cnt] : memf(m_addr[7:0]));
    end
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic p_auth(); auth_ok = 1; cyc(); auth_ok = 0; endtask
  task automatic p_wr();   wr_cmd = 1;  cyc(); wr_cmd = 0;  endtask
  task automatic p_end();  rd_end = 1;  cyc(); rd_end = 0;  endtask
  task automatic p_take(); dout_ready = 1; cyc(); dout_ready = 0; endtask
  task automatic p_start(input logic [7:0] a);
    rd_addr = a; rd_start = 1; cyc(); rd_start = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) cyc();
    chk("R1 valid in reset", dout_valid, 0);
    chk("R1 mode in reset", csum_mode, 0);
    rst_n = 1; cyc();
    chk("R1 valid", dout_valid, 0);
    chk("R1 mode", csum_mode, 0);
    chk("R1 addr", mem_addr, 0);

    // R2: write without authentication
    p_wr();
    chk("R2 no auth no arm", csum_mode, 0);
    p_start(8'h20);
    chk("R2 mem data", dout_data, memf(8'h20));
    chk("R2 not csum", dout_is_csum, 0);
    p_end();

    // R3, R9, R4, R6
    p_auth(); p_wr();
    chk("R2 armed", csum_mode, 1);
    p_start(8'h20);
    csum_in = C2;
    chk("R3 byte0", dout_data, 8'h01);
    chk("R3 is_csum", dout_is_csum, 1);
    cyc(); cyc();
    chk("R9 hold data", dout_data, 8'h01);
    chk("R9 hold addr", mem_addr, 8'h20);
    p_take();
    chk("R3 byte1", dout_data, 8'h23);
    chk("R7 addr step", mem_addr, 8'h21);
    p_take();
    chk("R3 byte2 captured", dout_data, 8'h45);
    p_end();
    chk("R4 mode off", csum_mode, 0);
    p_wr();
    chk("R6 no rearm", csum_mode, 0);
    p_start(8'h20);
    chk("R4 mem after", dout_is_csum, 0);
    chk("R4 mem data", dout_data, memf(8'h20));
    p_end();
    csum_in = C1;

    // R7: full overlay then memory from 0x28
    p_auth(); p_wr();
    p_start(8'h20);
    for (int i = 0; i < 7; i++) p_take();
    chk("R3 last byte", dout_data, 8'hEF);
    chk("R7 mode held", csum_mode, 1);
    p_take();
    chk("R7 not csum", dout_is_csum, 0);
    chk("R7 addr 28", mem_addr, 8'h28);
    chk("R7 data 28", dout_data, memf(8'h28));
    chk("R7 mode off", csum_mode, 0);
    p_take();
    chk("R7 data 29", dout_data, memf(8'h29));
    p_end();

    // R5: read at another address ends the mode
    p_auth(); p_wr();
    p_start(8'h10);
    chk("R5 mode off", csum_mode, 0);
    chk("R5 mem data", dout_data, memf(8'h10));
    p_end();
    p_start(8'h20);
    chk("R5 later not csum", dout_is_csum, 0);
    p_end();

    // R10: reset and authentication clear state
    p_auth(); p_wr();
    rst_n = 0; cyc(); rst_n = 1;
    chk("R10 reset clears", csum_mode, 0);
    chk("R10 reset valid", dout_valid, 0);
    p_wr();
    chk("R10 no auth after reset", csum_mode, 0);
    p_auth(); p_wr();
    chk("R10 rearm after auth", csum_mode, 1);
    p_auth();
    chk("R10 auth clears", csum_mode, 0);
    p_wr();
    chk("R6 new auth allows", csum_mode, 1);
    p_end();

    // R8: unlimited checksum reads
    unlim_rd_n = 0;
    p_auth(); p_wr();
    p_start(8'h20);
    chk("R8 first", dout_data, 8'h01);
    p_take(); p_end();
    chk("R8 mode kept", csum_mode, 1);
    p_start(8'h20);
    chk("R8 second csum", dout_is_csum, 1);
    p_end();
    p_start(8'h40);
    chk("R8 other read keeps", csum_mode, 1);
    p_end();
    p_start(8'h20);
    chk("R8 third", dout_data, 8'h01);
    p_end();
    unlim_rd_n = 1;

    cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule